// File: doc/BRIEF.md
# PCI Host I/O Initiator Sequencer

This block sits between a processor-side port request and a shared PCI-style bus. It turns each request into one single-data I/O transaction. A request carries an address, active-high byte enables, a read/write flag and write data. The requester holds the request steady until the block pulses `done`. On a read, the returned word is then available on `cpu_rdata`.

On the bus side the block waits for a grant. When the bus was last owned by another master, it spends one float clock first. It then drives one address clock (FRAME# low) and one or more data clocks (IRDY# low). The target either completes the transfer, holds it with wait states, or asks for a retry. A retry is re-issued by the block itself, with no action from the requester. A transfer that no target claims ends as a master abort. Every transaction is followed by one turnaround clock and a programmable recovery gap.

Top module: `pci_io_initiator`

## Requirements
- R1: After reset, `frame_n` and `irdy_n` are 1, `ad_oe`, `cbe_oe` and `done` are 0.
- R2: When `bus_gnt` is 1, a request is pending and `park_other` is 0 at a clock edge in the idle state, the next clock is the address clock. In that clock `frame_n`=0, `irdy_n`=1, `ad_out` is the request address, `ad_oe`=`cbe_oe`=1, and `cbe_out` is 4'b0010 for a read or 4'b0011 for a write. `frame_n` is low for exactly one clock per attempt.
- R3: If `park_other` is 1 at that accepting edge, exactly one clock with `frame_n`=1, `ad_oe`=0 and `cbe_oe`=0 precedes the address clock.
- R4: In data clocks `frame_n`=1, `irdy_n`=0 and `cbe_out` is the bitwise inverse of the request byte enables. On a write `ad_oe`=1 and `ad_out` is the write data. On a read `ad_oe`=0.
- R5: The data phase completes at an edge where `devsel_n`=0 and `trdy_n`=0. For a read, `ad_in` is captured into `cpu_rdata`. `done` is 1 for exactly the following clock. With an immediate target, `done` appears in the third clock after the request is presented (address, data, turnaround: four bus clocks including the accepting one).
- R6: While `devsel_n`=0 and `trdy_n`=1 (and `stop_n`=1), `irdy_n` stays 0. Once the target has claimed, no abort follows, however many wait states occur. Each wait clock adds one clock to the latency.
- R7: An edge in a data clock with `devsel_n`=0, `stop_n`=0 and `trdy_n`=1 ends the attempt without `done`. After turnaround and recovery, the same address, command and byte enables are re-issued automatically.
- R8: The clock after any data phase is a turnaround clock with `frame_n`=1, `irdy_n`=1 and both output enables 0.
- R9: The recovery length N is `recov_cfg` clamped to the range 2..4. Between the release of IRDY# and the next FRAME# there are exactly N+2 clocks with both signals high, whenever a request is waiting.
- R10: If `devsel_n` stays 1 for five data clocks, the attempt ends at the fifth data edge as a master abort. `done` is pulsed in the next clock, and a read returns all-ones.
- R11: While `bus_gnt` is 0 in the idle state, no address clock starts. The address clock follows the first edge that sees the grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request pending, held until `done` |
| req_addr | input | 32 | I/O port address |
| req_be | input | 4 | Byte enables, active high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data |
| recov_cfg | input | 3 | Recovery gap setting (clamped to 2..4) |
| done | output | 1 | One-clock completion pulse |
| cpu_rdata | output | 32 | Read return register |
| bus_gnt | input | 1 | Bus granted to this initiator |
| park_other | input | 1 | Bus last parked at another master |
| ad_out | output | 32 | Address/data value driven |
| ad_oe | output | 1 | Address/data output enable |
| cbe_out | output | 4 | Command / byte-enable lines (active-low enables) |
| cbe_oe | output | 1 | Command/byte-enable output enable |
| frame_n | output | 1 | FRAME#, address-phase marker |
| irdy_n | output | 1 | IRDY#, initiator ready |
| ad_in | input | 32 | Address/data value received |
| trdy_n | input | 1 | TRDY#, target ready |
| devsel_n | input | 1 | DEVSEL#, target claim |
| stop_n | input | 1 | STOP#, target retry request |

## Verification
The assertions assume a well-behaved requester. `req_valid` and the request fields stay constant from presentation until `done`, and `bus_gnt` is only sampled in the idle state. They also assume a target that only drives `devsel_n`, `trdy_n` and `stop_n` low while `irdy_n` is low. Each assertion rests on one of these two assumptions. The bench's target model reacts only to observed IRDY# clocks and releases all three responses as soon as IRDY# rises. The bench's requester changes its request only on the negative edge at which it sees `done`.

// File: rtl/pio_pkg.sv
package pio_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PARK,
    ST_ADDR,
    ST_DATA,
    ST_TURN,
    ST_RECOV
  } pio_state_e;

  localparam logic [3:0] CMD_IO_READ  = 4'b0010;
  localparam logic [3:0] CMD_IO_WRITE = 4'b0011;

endpackage

// File: rtl/pio_devsel_watch.sv
module pio_devsel_watch #(
  parameter int LIMIT = 5,
  localparam int CW = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic active,
  input  logic devsel_n,
  output logic timeout
);

  logic [CW-1:0] cnt;
  logic          seen;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt  <= '0;
      seen <= 1'b0;
    end else if (active) begin
      if (!devsel_n)
        seen <= 1'b1;
      else if (!seen)
        cnt <= cnt + CW'(1);
    end
  end

  assign timeout = active && devsel_n && !seen && (cnt == CW'(LIMIT - 1));

  // once a target has claimed, the attempt can no longer time out
  assert_claim_blocks_abort_R6: assert property (@(posedge clk) disable iff (rst)
    (active && !devsel_n && !clear) |=> !timeout);

endmodule

// File: rtl/pio_recov_timer.sv
module pio_recov_timer #(
  parameter int W   = 3,
  parameter int MIN = 2,
  parameter int MAX = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (load)
      cnt <= load_val - W'(1);
    else if (cnt != '0)
      cnt <= cnt - W'(1);
  end

  assign expired = (cnt == '0);

  // the clamp in the sequencer must deliver an in-range gap
  assert_recov_range_R9: assert property (@(posedge clk) disable iff (rst)
    load |-> (load_val >= W'(MIN)) && (load_val <= W'(MAX)));

endmodule

// File: rtl/pci_io_initiator.sv
module pci_io_initiator
  import pio_pkg::*;
#(
  parameter int AD_W         = 32,
  parameter int RECOV_W      = 3,
  parameter int RECOV_MIN    = 2,
  parameter int RECOV_MAX    = 4,
  parameter int DEVSEL_LIMIT = 5,
  localparam int BE_W        = AD_W / 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [AD_W-1:0]    req_addr,
  input  logic [BE_W-1:0]    req_be,
  input  logic               req_write,
  input  logic [AD_W-1:0]    req_wdata,
  input  logic [RECOV_W-1:0] recov_cfg,
  output logic               done,
  output logic [AD_W-1:0]    cpu_rdata,
  input  logic               bus_gnt,
  input  logic               park_other,
  output logic [AD_W-1:0]    ad_out,
  output logic               ad_oe,
  output logic [BE_W-1:0]    cbe_out,
  output logic               cbe_oe,
  output logic               frame_n,
  output logic               irdy_n,
  input  logic [AD_W-1:0]    ad_in,
  input  logic               trdy_n,
  input  logic               devsel_n,
  input  logic               stop_n
);

  pio_state_e state_q, state_d;

  logic [AD_W-1:0]    lat_addr, lat_wdata;
  logic [BE_W-1:0]    lat_be;
  logic               lat_wr;
  logic               retry_pend;

  logic               start;
  logic               fin_ok, fin_retry, fin_abort;
  logic               dev_timeout, recov_expired;
  logic [RECOV_W-1:0] recov_len;

  logic [AD_W-1:0]    cur_addr, cur_wdata;
  logic [BE_W-1:0]    cur_be;
  logic               cur_wr;

  // fresh request fields at acceptance, latched copy afterwards and on retry
  always_comb begin
    if (state_q == ST_IDLE && !retry_pend) begin
      cur_addr  = req_addr;
      cur_wdata = req_wdata;
      cur_be    = req_be;
      cur_wr    = req_write;
    end else begin
      cur_addr  = lat_addr;
      cur_wdata = lat_wdata;
      cur_be    = lat_be;
      cur_wr    = lat_wr;
    end
  end

  always_comb begin
    if (recov_cfg < RECOV_W'(RECOV_MIN))
      recov_len = RECOV_W'(RECOV_MIN);
    else if (recov_cfg > RECOV_W'(RECOV_MAX))
      recov_len = RECOV_W'(RECOV_MAX);
    else
      recov_len = recov_cfg;
  end

  assign start     = (state_q == ST_IDLE) && bus_gnt && (req_valid || retry_pend);
  assign fin_ok    = (state_q == ST_DATA) && !devsel_n && !trdy_n;
  assign fin_retry = (state_q == ST_DATA) && !devsel_n && trdy_n && !stop_n;
  assign fin_abort = dev_timeout;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start) state_d = park_other ? ST_PARK : ST_ADDR;
      ST_PARK:  state_d = ST_ADDR;
      ST_ADDR:  state_d = ST_DATA;
      ST_DATA:  if (fin_ok || fin_retry || fin_abort) state_d = ST_TURN;
      ST_TURN:  state_d = ST_RECOV;
      ST_RECOV: if (recov_expired) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  pio_devsel_watch #(
    .LIMIT(DEVSEL_LIMIT)
  ) i_watch (
    .clk     (clk),
    .rst     (rst),
    .clear   (state_q == ST_ADDR),
    .active  (state_q == ST_DATA),
    .devsel_n(devsel_n),
    .timeout (dev_timeout)
  );

  pio_recov_timer #(
    .W  (RECOV_W),
    .MIN(RECOV_MIN),
    .MAX(RECOV_MAX)
  ) i_recov (
    .clk     (clk),
    .rst     (rst),
    .load    (state_q == ST_TURN),
    .load_val(recov_len),
    .expired (recov_expired)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      lat_addr   <= '0;
      lat_wdata  <= '0;
      lat_be     <= '0;
      lat_wr     <= 1'b0;
      retry_pend <= 1'b0;
    end else begin
      state_q <= state_d;
      if (start) begin
        lat_addr   <= cur_addr;
        lat_wdata  <= cur_wdata;
        lat_be     <= cur_be;
        lat_wr     <= cur_wr;
        retry_pend <= 1'b0;
      end else if (fin_retry) begin
        retry_pend <= 1'b1;
      end
    end
  end

  // registered bus and return outputs, decoded from the next state
  always_ff @(posedge clk) begin
    if (rst) begin
      frame_n   <= 1'b1;
      irdy_n    <= 1'b1;
      ad_oe     <= 1'b0;
      cbe_oe    <= 1'b0;
      ad_out    <= '0;
      cbe_out   <= '1;
      done      <= 1'b0;
      cpu_rdata <= '0;
    end else begin
      frame_n <= (state_d != ST_ADDR);
      irdy_n  <= (state_d != ST_DATA);
      cbe_oe  <= (state_d == ST_ADDR) || (state_d == ST_DATA);
      ad_oe   <= (state_d == ST_ADDR) || ((state_d == ST_DATA) && cur_wr);
      if (state_d == ST_ADDR) begin
        ad_out  <= cur_addr;
        cbe_out <= cur_wr ? CMD_IO_WRITE : CMD_IO_READ;
      end else if (state_d == ST_DATA) begin
        ad_out  <= cur_wdata;
        cbe_out <= ~cur_be;
      end else begin
        ad_out  <= '0;
        cbe_out <= '1;
      end
      done <= fin_ok || fin_abort;
      if (fin_ok && !lat_wr)
        cpu_rdata <= ad_in;
      else if (fin_abort && !lat_wr)
        cpu_rdata <= '1;
    end
  end

  assert_addr_single_clock_R2: assert property (@(posedge clk) disable iff (rst)
    !frame_n |=> frame_n && !irdy_n);

  assert_park_float_R3: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && bus_gnt && (req_valid || retry_pend) && park_other)
      |=> frame_n && !ad_oe && !cbe_oe);

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_turnaround_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(irdy_n) |-> frame_n && !ad_oe && !cbe_oe);

  assert_no_frame_without_grant_R11: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && !bus_gnt) |=> frame_n);

endmodule

// File: tb/test_pci_io_initiator.sv
module test_pci_io_initiator;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [3:0]  req_be = '0;
  logic        req_write = 1'b0;
  logic [31:0] req_wdata = '0;
  logic [2:0]  recov_cfg = 3'd2;
  logic        done;
  logic [31:0] cpu_rdata;
  logic        bus_gnt = 1'b1;
  logic        park_other = 1'b0;
  logic [31:0] ad_out;
  logic        ad_oe;
  logic [3:0]  cbe_out;
  logic        cbe_oe;
  logic        frame_n;
  logic        irdy_n;
  logic [31:0] ad_in = '0;
  logic        trdy_n = 1'b1;
  logic        devsel_n = 1'b1;
  logic        stop_n = 1'b1;

  always #10 clk = ~clk;

  pci_io_initiator i_pci_io_initiator (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_be(req_be), .req_write(req_write), .req_wdata(req_wdata),
    .recov_cfg(recov_cfg), .done(done), .cpu_rdata(cpu_rdata),
    .bus_gnt(bus_gnt), .park_other(park_other), .ad_out(ad_out),
    .ad_oe(ad_oe), .cbe_out(cbe_out), .cbe_oe(cbe_oe), .frame_n(frame_n),
    .irdy_n(irdy_n), .ad_in(ad_in), .trdy_n(trdy_n), .devsel_n(devsel_n),
    .stop_n(stop_n)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  // observations of the last access
  int          lat_done, fr_first, nfr;
  logic [31:0] ad_first, ad_last, dp_ad, rd_got;
  logic [3:0]  cbe_first, cbe_last, dp_cbe;
  logic        oe_first, dp_oe;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic access(input logic [31:0] addr, input logic [3:0] be, input logic wr,
                        input logic [31:0] wdata, input logic park, input int gnt_delay,
                        input int wait_c, input int retries, input bit nodev,
                        input logic [31:0] rvalue);
    int lat = 0;
    int dc = 0;
    int retry_left = retries;
    bit stop_given = 0;
    bit got = 0;
    @(negedge clk);
    req_valid = 1'b1; req_addr = addr; req_be = be; req_write = wr; req_wdata = wdata;
    park_other = park; bus_gnt = (gnt_delay == 0);
    fr_first = 0; nfr = 0; lat_done = 0;
    while (!got && lat < 60) begin
      @(negedge clk);
      lat++;
      if (lat == gnt_delay) bus_gnt = 1'b1;
      if (!frame_n) begin
        nfr++;
        if (nfr == 1) begin
          fr_first = lat; ad_first = ad_out; cbe_first = cbe_out; oe_first = ad_oe && cbe_oe;
        end
        ad_last = ad_out; cbe_last = cbe_out;
      end
      if (!irdy_n) begin dp_ad = ad_out; dp_cbe = cbe_out; dp_oe = ad_oe; end
      if (done) begin got = 1; lat_done = lat; rd_got = cpu_rdata; end
      if (irdy_n) begin
        devsel_n = 1; trdy_n = 1; stop_n = 1; dc = 0;
        if (stop_given) begin retry_left--; stop_given = 0; end
      end else begin
        dc++;
        if (nodev) begin
          devsel_n = 1; trdy_n = 1; stop_n = 1;
        end else if (retry_left > 0) begin
          devsel_n = 0; stop_n = 0; trdy_n = 1; stop_given = 1;
        end else if (dc > wait_c) begin
          devsel_n = 0; trdy_n = 0; ad_in = rvalue;
        end else begin
          devsel_n = 0; trdy_n = 1;
        end
      end
    end
    req_valid = 1'b0; park_other = 1'b0; bus_gnt = 1'b1;
    devsel_n = 1; trdy_n = 1; stop_n = 1;
  endtask

  initial begin
    #(20 * 100000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state {frame_n, irdy_n, ad_oe, cbe_oe, done}
    chk("R1 reset outputs", {27'd0, frame_n, irdy_n, ad_oe, cbe_oe, done}, 32'b11000);

    // R2 R5 R6: reads with 0..3 wait states
    for (int w = 0; w < 4; w++) begin
      idle(8);
      access(32'h0000_03F8 + w, 4'b0001, 1'b0, '0, 1'b0, 0, w, 0, 1'b0, 32'hA5A5_0000 ^ w);
      chk("R2 frame clock", fr_first, 1);
      chk("R2 read address", ad_first, 32'h0000_03F8 + w);
      chk("R2 read command", {28'd0, cbe_first}, 32'h2);
      chk("R5 R6 read latency", lat_done, 3 + w);
      chk("R5 read data", rd_got, 32'hA5A5_0000 ^ w);
      chk("R4 read data-phase ad_oe", {31'd0, dp_oe}, 0);
    end

    // R4 write data phase
    idle(8);
    access(32'h0000_0080, 4'b0101, 1'b1, 32'hDEAD_BEEF, 1'b0, 0, 0, 0, 1'b0, '0);
    chk("R2 write command", {28'd0, cbe_first}, 32'h3);
    chk("R4 write data", dp_ad, 32'hDEAD_BEEF);
    chk("R4 byte enables", {28'd0, dp_cbe}, 32'hA);
    chk("R4 write ad_oe", {31'd0, dp_oe}, 1);
    chk("R5 write latency", lat_done, 3);

    // R3 park handover
    idle(8);
    access(32'h0000_0060, 4'b1111, 1'b0, '0, 1'b1, 0, 0, 0, 1'b0, 32'h1234_5678);
    chk("R3 park delays frame", fr_first, 2);
    chk("R3 park latency", lat_done, 4);

    // R10 master abort
    idle(8);
    access(32'h0000_0300, 4'b0011, 1'b0, '0, 1'b0, 0, 0, 0, 1'b1, '0);
    chk("R10 abort latency", lat_done, 7);
    chk("R10 abort read data", rd_got, 32'hFFFF_FFFF);

    // R11 grant withheld for four clocks
    idle(8);
    access(32'h0000_0070, 4'b0001, 1'b0, '0, 1'b0, 4, 0, 0, 1'b0, 32'h0F0F_0F0F);
    chk("R11 frame waits for grant", fr_first, 5);
    chk("R11 latency", lat_done, 7);

    // R7 R9: retry once, sweep every recovery setting
    for (int r = 0; r < 8; r++) begin
      int n;
      n = (r < 2) ? 2 : ((r > 4) ? 4 : r);
      recov_cfg = 3'(r);
      idle(8);
      access(32'h0000_0400 + r, 4'b0110, 1'b0, '0, 1'b0, 0, 0, 1, 1'b0, 32'h5000_0000 + r);
      chk("R7 R9 retry latency", lat_done, n + 7);
      chk("R7 reissue count", nfr, 2);
      chk("R7 reissue address", ad_last, 32'h0000_0400 + r);
      chk("R7 reissue command", {28'd0, cbe_last}, {28'd0, cbe_first});
      chk("R7 retried data", rd_got, 32'h5000_0000 + r);
    end

    // R8 R9: back-to-back accesses, idle clocks between IRDY# release and FRAME#
    for (int r = 2; r < 5; r++) begin
      recov_cfg = 3'(r);
      idle(8);
      access(32'h0000_0500, 4'b0001, 1'b1, 32'h11, 1'b0, 0, 0, 0, 1'b0, '0);
      access(32'h0000_0504, 4'b0001, 1'b1, 32'h22, 1'b0, 0, 0, 0, 1'b0, '0);
      // idle clocks = fr_first + 1 = N + 2
      chk("R8 R9 back-to-back gap", fr_first + 1, r + 2);
      chk("R9 second address", ad_first, 32'h0000_0504);
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule